// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

This block generates a table of polynomial values using nothing but additions. It keeps a value register and a cascade of six difference registers. On every step, each register absorbs the register one order above it. The top-order register never changes, so any polynomial of degree six or lower can be tabulated one entry per clock. The block has no multiplier and no divider.

A host first writes the starting value and the forward differences at the starting point through a simple write port. It then pulses a step input. Each accepted step produces the next table entry on the following cycle, together with a one-cycle valid pulse and the running step index. A sticky flag records whether any addition wrapped past the register width.

Top module: `fdiff_tab`

## Requirements
- R1: After reset the value, all six differences, the step index, the valid flag and the overflow flag are all zero.
- R2: A write with `stepEn` low and `loadIdx` 0 sets the value register, and `value` shows the new contents on the next cycle. Indices 1 to 6 set difference orders 1 to 6. Index 7 writes no register.
- R3: Any accepted write (`loadEn` high, `stepEn` low), whatever its index, clears the step index and the overflow flag on the next cycle.
- R4: A write presented in the same cycle as a step is ignored, and the step proceeds normally.
- R5: On a step, all registers update in parallel from their old contents. The value becomes value + d1. Each dk for k = 1..5 becomes dk + d(k+1). d6 is unchanged. As a result, the forward differences of any polynomial of degree six or lower reproduce that polynomial exactly.
- R6: `valueValid` is high for exactly the one cycle after each step and low otherwise. While neither a step nor a write occurs, `value` holds.
- R7: `stepNum` increments by one on every step. It is reported in the same cycle as the value it belongs to.
- R8: If any of the six additions carries out of the 108-bit width, the result is kept modulo 2^108 and `overflow` is set. It then stays set until reset or an accepted write.
- R9: Loading value 41, d1 = 2 and d2 = 2 (all other differences 0) and then stepping gives the values 43, 47, 53 and 61.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write strobe for the register bank |
| loadIdx | input | 3 | Register select: 0 selects the value register, 1 to 6 select the differences |
| loadData | input | 108 | Data to write |
| stepEn | input | 1 | Advance the table by one entry |
| value | output | 108 | Current polynomial value |
| valueValid | output | 1 | One-cycle pulse marking a freshly stepped value |
| stepNum | output | 32 | Steps taken since the last write |
| overflow | output | 1 | Sticky wrap indicator |

## Verification
Every result of a step or a write comes from a register that is clocked at the edge where the stimulus is sampled. The new value, the valid pulse, the step index and the overflow flag are therefore all due exactly one cycle after the stimulus. The bench drives its inputs and samples the outputs on the falling edge, so a result caused at a rising edge is read half a period later. A behavioural reference model updates at that same rising edge and is compared against the design on every falling edge. Directed checks are added for the n² + n + 41 table, a sixth-degree polynomial evaluated directly, a write that collides with a step, and wrap in both the value adder and a difference adder.

// File: rtl/fdiff_pkg.sv
package fdiff_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // accepted register write
    logic step;   // advance the table
  } ctlStrobe_t;
endpackage

// File: rtl/fdiff_ctrl.sv
module fdiff_ctrl
  import fdiff_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic             stepEn,
  output ctlStrobe_t       strobe,
  output logic             valueValid,
  output logic [CNT_W-1:0] stepNum
);
  // A step takes precedence; a write that collides with it is dropped
  always_comb begin
    strobe.step = stepEn;
    strobe.load = loadEn && !stepEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueValid <= 1'b0;
      stepNum    <= '0;
    end else begin
      valueValid <= strobe.step;
      if (strobe.step)
        stepNum <= stepNum + 1'b1;
      else if (strobe.load)
        stepNum <= '0;
    end
  end
endmodule

// File: rtl/fdiff_dp.sv
module fdiff_dp
  import fdiff_pkg::*;
#(
  parameter int WIDTH  = 108,
  parameter int ORDERS = 6,
  parameter int IDX_W  = $clog2(ORDERS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] value,
  output logic             overflow
);
  localparam int NREG = ORDERS + 1;

  // bank[0] is the value, bank[k] is the k-th difference
  logic [NREG-1:0][WIDTH-1:0]   bank;
  logic [ORDERS-1:0][WIDTH-1:0] sumLo;
  logic [ORDERS-1:0]            carry;

  genvar k;
  generate
    for (k = 0; k < ORDERS; k++) begin : gAdd
      assign {carry[k], sumLo[k]} = {1'b0, bank[k]} + {1'b0, bank[k+1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bank <= '0;
    end else if (strobe.step) begin
      for (int j = 0; j < ORDERS; j++)
        bank[j] <= sumLo[j];
    end else if (strobe.load) begin
      for (int j = 0; j < NREG; j++)
        if (loadIdx == IDX_W'(j))
          bank[j] <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      overflow <= 1'b0;
    else if (strobe.step && (|carry))
      overflow <= 1'b1;
    else if (strobe.load)
      overflow <= 1'b0;
  end

  assign value = bank[0];
endmodule

// File: rtl/fdiff_tab.sv
module fdiff_tab
  import fdiff_pkg::*;
#(
  parameter int WIDTH  = 108,
  parameter int ORDERS = 6,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = $clog2(ORDERS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [WIDTH-1:0] loadData,
  input  logic             stepEn,
  output logic [WIDTH-1:0] value,
  output logic             valueValid,
  output logic [CNT_W-1:0] stepNum,
  output logic             overflow
);
  ctlStrobe_t strobe;

  fdiff_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .stepEn(stepEn),
    .strobe(strobe), .valueValid(valueValid), .stepNum(stepNum)
  );

  fdiff_dp #(.WIDTH(WIDTH), .ORDERS(ORDERS), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(loadIdx),
    .loadData(loadData), .value(value), .overflow(overflow)
  );
endmodule

// File: rtl/fdiff_tab_chk.sv
module fdiff_tab_chk #(
  parameter int WIDTH = 108,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadEn,
  input logic             stepEn,
  input logic [WIDTH-1:0] value,
  input logic             valueValid,
  input logic [CNT_W-1:0] stepNum,
  input logic             overflow
);
  // R6
  step_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn |=> valueValid);
  // R6
  idle_novalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> !valueValid);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !loadEn) |=> $stable(value));
  // R7
  count_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn |=> stepNum == CNT_W'($past(stepNum) + 1));
  // R3
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !stepEn) |=> (stepNum == '0) && !overflow);
  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !(loadEn && !stepEn)) |=> overflow);
endmodule

bind fdiff_tab fdiff_tab_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .stepEn(stepEn), .value(value),
  .valueValid(valueValid), .stepNum(stepNum), .overflow(overflow)
);

// File: tb/sim_fdiff_tab.sv
module sim_fdiff_tab;
  localparam int W   = 108;
  localparam int ORD = 6;
  localparam int IW  = 3;
  localparam int CW  = 32;

  logic clk = 1'b0, rstN = 1'b0, loadEn = 1'b0, stepEn = 1'b0;
  logic [IW-1:0] loadIdx = '0;
  logic [W-1:0]  loadData = '0;
  logic [W-1:0]  value;
  logic          valueValid, overflow;
  logic [CW-1:0] stepNum;

  fdiff_tab u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadData(loadData), .stepEn(stepEn), .value(value),
    .valueValid(valueValid), .stepNum(stepNum), .overflow(overflow)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  logic running = 1'b0;

  // Behavioural reference model
  logic [W-1:0] mf [0:ORD];
  logic [W-1:0] old [0:ORD];
  logic [W:0]   tmp;
  logic         mValid, mOvf;
  logic [CW-1:0] mN;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j <= ORD; j++) mf[j] = '0;
      mValid = 1'b0; mOvf = 1'b0; mN = '0;
    end else begin
      mValid = stepEn;
      if (stepEn) begin
        old = mf;
        for (int j = 0; j < ORD; j++) begin
          tmp = {1'b0, old[j]} + {1'b0, old[j+1]};
          mf[j] = tmp[W-1:0];
          if (tmp[W]) mOvf = 1'b1;
        end
        mN = mN + 1'b1;
      end else if (loadEn) begin
        if (int'(loadIdx) <= ORD) mf[loadIdx] = loadData;
        mN = '0; mOvf = 1'b0;
      end
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(phase, "model value", value, mf[0]);
      chk(phase, "model valid", W'(valueValid), W'(mValid));
      chk(phase, "model stepNum", W'(stepNum), W'(mN));
      chk(phase, "model overflow", W'(overflow), W'(mOvf));
    end
  end

  // Stimulus tasks: entered on a falling edge, return on the next one
  task automatic doLoad(int idx, logic [W-1:0] d);
    loadEn = 1'b1; stepEn = 1'b0; loadIdx = IW'(idx); loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic doStep();
    stepEn = 1'b1;
    @(negedge clk);
    stepEn = 1'b0;
  endtask

  task automatic doIdle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [W-1:0] poly(int n);
    logic [W-1:0] x = W'(n);
    return x*x*x*x*x*x + W'(7)*x*x*x + W'(5);
  endfunction

  logic [W-1:0] tbl [0:ORD];
  logic [W-1:0] allOnes;

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    allOnes = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;
    // R1 reset state
    chk("R1", "value", value, '0);
    chk("R1", "valid", W'(valueValid), '0);
    chk("R1", "stepNum", W'(stepNum), '0);
    chk("R1", "overflow", W'(overflow), '0);

    // R2 loads, including out-of-range index 7
    phase = "R2";
    doLoad(0, 41);
    chk("R2", "value after load", value, 41);
    chk("R2", "no valid on load", W'(valueValid), '0);
    doLoad(1, 2);
    doLoad(2, 2);
    doLoad(7, 999);
    chk("R2", "index 7 leaves value", value, 41);

    // R9 quadratic table, with R7 count and R6 valid
    phase = "R9";
    for (int i = 1; i <= 4; i++) begin
      doStep();
      chk("R9", "quadratic value", value, W'(41 + i*i + i));
      chk("R7", "stepNum", W'(stepNum), W'(i));
      chk("R6", "valid after step", W'(valueValid), 1);
    end
    doIdle(2);
    chk("R6", "valid low when idle", W'(valueValid), 0);
    chk("R6", "value holds", value, 61);

    // R4 write colliding with a step is dropped
    phase = "R4";
    loadEn = 1'b1; loadIdx = '0; loadData = 5;
    doStep();
    loadEn = 1'b0;
    chk("R4", "step wins over write", value, 71);
    chk("R4", "stepNum continues", W'(stepNum), 5);

    // R5 sixth-degree polynomial from host-computed forward differences
    phase = "R5";
    for (int j = 0; j <= ORD; j++) tbl[j] = poly(j);
    for (int lvl = 1; lvl <= ORD; lvl++)
      for (int j = ORD; j >= lvl; j--) tbl[j] = tbl[j] - tbl[j-1];
    for (int j = 0; j <= ORD; j++) doLoad(j, tbl[j]);
    chk("R3", "load clears stepNum", W'(stepNum), 0);
    for (int i = 1; i <= 20; i++) begin
      doStep();
      chk("R5", "sixth-degree value", value, poly(i));
    end

    // R8 wrap in the value adder
    phase = "R8";
    doLoad(0, allOnes);
    doLoad(1, 1);
    for (int j = 2; j <= ORD; j++) doLoad(j, 0);
    doStep();
    chk("R8", "wrapped value", value, '0);
    chk("R8", "overflow set", W'(overflow), 1);
    doStep();
    chk("R8", "overflow sticky", W'(overflow), 1);
    chk("R8", "value after wrap", value, 1);
    phase = "R3";
    doLoad(0, 0);
    chk("R3", "load clears overflow", W'(overflow), 0);
    // R8 wrap in a difference adder
    phase = "R8";
    doLoad(1, allOnes);
    doLoad(2, 2);
    doStep();
    chk("R8", "value no wrap", value, allOnes);
    chk("R8", "difference wrap flags", W'(overflow), 1);
    doIdle(2);

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule